// File: doc/BRIEF.md
# Potentiometer Digitizer Sequencer

This block measures the wiper voltage of one of up to 24 front-panel potentiometers. It uses an external 12-bit DAC and one analog comparator. A start request carries a 5-bit pot index. The block decodes that index into two parts. The first is a 3-bit code that picks one input of an 8-way analog selector. The second is an active-low inhibit that enables exactly one of three such selectors. Before any selector is enabled, the code is latched while every inhibit is held high, so no transient reaches the comparator.

The block then runs a 12-step successive-approximation search, starting at the most significant bit. Each trial code is written to the DAC data register as a low byte and then a high byte, each with its own strobe. After a programmable settle delay the comparator is sampled. The bit under trial is kept when the comparator reports the wiper above the DAC level, and cleared otherwise. When the search ends, the 12-bit result appears together with a one-cycle done pulse.

The state machine has seven states:

- IDLE waits for a start request.
- SELECT latches the code with all inhibits high.
- WR_LO strobes the low byte.
- WR_HI strobes the high byte and loads the settle timer.
- SETTLE waits for the timer.
- SAMPLE applies the comparator decision.
- FINISH emits done.

The transitions are:

- IDLE to SELECT on an accepted start.
- IDLE to IDLE on a rejected index, which raises the error flag.
- SELECT to WR_LO, WR_LO to WR_HI, and WR_HI to SETTLE.
- SETTLE to SAMPLE when the timer reaches zero.
- SAMPLE to WR_LO while bits remain, or SAMPLE to FINISH after bit 0.
- FINISH to IDLE.

Top module: `pot_sar_seq`

## Requirements
- R1: Bits [2:0] of the pot index are latched onto `pot_code_o` when a start is accepted. The code holds after the conversion until the next accepted start, and reset clears it to 0.
- R2: A start with an index of 24 to 31 (bits [4:3] = 3) is rejected. `err_o` is high for exactly the one cycle after the start. No conversion begins and the inhibits stay high.
- R3: All three inhibits are high while the block is idle and during the SELECT cycle that follows an accepted start. At no time is more than one inhibit low.
- R4: During every DAC write, inhibit bit n is the only one low, where n = index bits [4:3] (0, 1 or 2).
- R5: A conversion makes 12 trials. Each trial strobes `dac_lo_stb_o` with trial bits [7:0] on `dac_data_o`. In the next cycle it strobes `dac_hi_stb_o` with {4'b0, trial bits [11:8]}. The two strobes are never high together.
- R6: Let S be the settle count captured at start. The comparator is sampled S+2 cycles after the high-byte strobe cycle. The next low-byte strobe follows exactly S+3 cycles after the high-byte strobe.
- R7: The search starts from trial 0x800 and runs MSB first. A bit is kept when `cmp_above_i` is 1. The result is therefore the largest code below the wiper level: 0 for a wiper at or below 0, and 4095 for a wiper above every code.
- R8: `done_o` is high for exactly one cycle, with the final value on `result_o`. `busy_o` falls in the following cycle. `result_o` holds until the next done.
- R9: A start request while `busy_o` is high is ignored. The result and the code belong to the conversion in progress.
- R10: After reset, `busy_o`, `done_o`, `err_o` and both strobes are 0, the inhibits are all 1, and `result_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request |
| pot_idx_i | input | 5 | Pot index; [4:3] selects the selector, [2:0] is the select code |
| settle_cyc_i | input | 8 | Settle count, captured at start |
| cmp_above_i | input | 1 | Comparator: 1 when the wiper is above the DAC level |
| dac_data_o | output | 8 | DAC byte data |
| dac_lo_stb_o | output | 1 | Low-byte write strobe |
| dac_hi_stb_o | output | 1 | High-byte write strobe |
| pot_code_o | output | 3 | Latched select code |
| sel_inh_n_o | output | 3 | Active-low selector inhibits |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 12 | Conversion result |
| err_o | output | 1 | Rejected-index pulse |

## Verification
The bench uses the default parameters: a 12-bit DAC, 8-bit bytes, three selectors of eight inputs, and an 8-bit settle count. At run time it drives settle counts from 0 to 5. These counts make the settle window visible.

The bench models the DAC register from the two strobes. For the first S cycles after each high-byte write it forces the comparator to report "above". A sample taken too early therefore produces a visibly larger result.

The wiper values cover zero, the exact midpoint, one below full scale and above full scale. Together these reach both result clamps and every selector.

// File: rtl/pot_sar_pkg.sv
package pot_sar_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SELECT,
        ST_WR_LO,
        ST_WR_HI,
        ST_SETTLE,
        ST_SAMPLE,
        ST_FINISH
    } sar_state_t;

endpackage

// File: rtl/pot_addr_decode.sv
module pot_addr_decode #(
    parameter int IDX_W   = 5,
    parameter int CODE_W  = 3,
    parameter int NUM_SEL = 3
) (
    input  logic [IDX_W-1:0]   idx,
    output logic [NUM_SEL-1:0] sel_onehot,
    output logic [CODE_W-1:0]  code,
    output logic               valid
);
    localparam int GRP_W = IDX_W - CODE_W;

    logic [GRP_W-1:0] grp;

    assign grp   = idx[IDX_W-1:CODE_W];
    assign code  = idx[CODE_W-1:0];
    assign valid = (32'(grp) < NUM_SEL);

    for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
        assign sel_onehot[g] = (grp == GRP_W'(g));
    end

endmodule

// File: rtl/pot_settle_timer.sv
module pot_settle_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         en,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (en && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/pot_sar_seq.sv
module pot_sar_seq
    import pot_sar_pkg::*;
#(
    parameter int DAC_W    = 12,
    parameter int BYTE_W   = 8,
    parameter int CODE_W   = 3,
    parameter int NUM_SEL  = 3,
    parameter int IDX_W    = 5,
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [IDX_W-1:0]    pot_idx_i,
    input  logic [SETTLE_W-1:0] settle_cyc_i,
    input  logic                cmp_above_i,
    output logic [BYTE_W-1:0]   dac_data_o,
    output logic                dac_lo_stb_o,
    output logic                dac_hi_stb_o,
    output logic [CODE_W-1:0]   pot_code_o,
    output logic [NUM_SEL-1:0]  sel_inh_n_o,
    output logic                busy_o,
    output logic                done_o,
    output logic [DAC_W-1:0]    result_o,
    output logic                err_o
);
    localparam int BIT_W = $clog2(DAC_W);

    sar_state_t            state_q, state_d;
    logic [DAC_W-1:0]      trial_q;
    logic [BIT_W-1:0]      bit_q;
    logic [NUM_SEL-1:0]    sel_q;
    logic [CODE_W-1:0]     code_q;
    logic [SETTLE_W-1:0]   settle_q;
    logic [DAC_W-1:0]      result_q;
    logic                  err_q;

    logic [NUM_SEL-1:0]    dec_onehot;
    logic [CODE_W-1:0]     dec_code;
    logic                  dec_valid;
    logic                  tmr_zero;
    logic                  accept;

    pot_addr_decode #(
        .IDX_W  (IDX_W),
        .CODE_W (CODE_W),
        .NUM_SEL(NUM_SEL)
    ) u_dec (
        .idx       (pot_idx_i),
        .sel_onehot(dec_onehot),
        .code      (dec_code),
        .valid     (dec_valid)
    );

    pot_settle_timer #(
        .W(SETTLE_W)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (state_q == ST_WR_HI),
        .load_val(settle_q),
        .en      (state_q == ST_SETTLE),
        .zero    (tmr_zero)
    );

    assign accept = (state_q == ST_IDLE) && start_i && dec_valid;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_SELECT;
            ST_SELECT: state_d = ST_WR_LO;
            ST_WR_LO:  state_d = ST_WR_HI;
            ST_WR_HI:  state_d = ST_SETTLE;
            ST_SETTLE: if (tmr_zero) state_d = ST_SAMPLE;
            ST_SAMPLE: state_d = (bit_q == '0) ? ST_FINISH : ST_WR_LO;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            trial_q  <= '0;
            bit_q    <= '0;
            sel_q    <= '0;
            code_q   <= '0;
            settle_q <= '0;
            result_q <= '0;
            err_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= (state_q == ST_IDLE) && start_i && !dec_valid;
            if (accept) begin
                code_q   <= dec_code;
                sel_q    <= dec_onehot;
                settle_q <= settle_cyc_i;
            end
            if (state_q == ST_SELECT) begin
                trial_q <= {1'b1, {(DAC_W-1){1'b0}}};
                bit_q   <= BIT_W'(DAC_W - 1);
            end
            if (state_q == ST_SAMPLE) begin
                trial_q[bit_q] <= cmp_above_i;
                if (bit_q != '0) begin
                    trial_q[bit_q - 1'b1] <= 1'b1;
                    bit_q                 <= bit_q - 1'b1;
                end else begin
                    result_q <= {trial_q[DAC_W-1:1], cmp_above_i};
                end
            end
        end
    end

    // Output decode
    always_comb begin
        dac_data_o   = '0;
        dac_lo_stb_o = 1'b0;
        dac_hi_stb_o = 1'b0;
        sel_inh_n_o  = '1;
        busy_o       = (state_q != ST_IDLE);
        done_o       = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_SELECT: ;
            ST_WR_LO: begin
                dac_data_o   = trial_q[BYTE_W-1:0];
                dac_lo_stb_o = 1'b1;
                sel_inh_n_o  = ~sel_q;
            end
            ST_WR_HI: begin
                dac_data_o   = BYTE_W'(trial_q[DAC_W-1:BYTE_W]);
                dac_hi_stb_o = 1'b1;
                sel_inh_n_o  = ~sel_q;
            end
            ST_SETTLE, ST_SAMPLE: sel_inh_n_o = ~sel_q;
            ST_FINISH: done_o = 1'b1;
            default: ;
        endcase
    end

    assign pot_code_o = code_q;
    assign result_o   = result_q;
    assign err_o      = err_q;

endmodule

// File: rtl/pot_sar_chk.sv
module pot_sar_chk #(
    parameter int DAC_W   = 12,
    parameter int BYTE_W  = 8,
    parameter int CODE_W  = 3,
    parameter int NUM_SEL = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               dac_lo_stb_o,
    input logic               dac_hi_stb_o,
    input logic [CODE_W-1:0]  pot_code_o,
    input logic [NUM_SEL-1:0] sel_inh_n_o,
    input logic               busy_o,
    input logic               done_o,
    input logic [DAC_W-1:0]   result_o,
    input logic               err_o
);
    assert_inh_onehot0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~sel_inh_n_o));

    assert_idle_inh_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (&sel_inh_n_o));

    assert_write_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_lo_stb_o || dac_hi_stb_o) |-> !(&sel_inh_n_o));

    assert_stb_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(dac_lo_stb_o && dac_hi_stb_o));

    assert_hi_after_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dac_hi_stb_o |-> $past(dac_lo_stb_o));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_then_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

    assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));

    assert_err_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !busy_o);

    assert_code_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(&sel_inh_n_o) |-> $stable(pot_code_o));

endmodule

bind pot_sar_seq pot_sar_chk #(
    .DAC_W  (DAC_W),
    .BYTE_W (BYTE_W),
    .CODE_W (CODE_W),
    .NUM_SEL(NUM_SEL)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dac_lo_stb_o(dac_lo_stb_o),
    .dac_hi_stb_o(dac_hi_stb_o),
    .pot_code_o  (pot_code_o),
    .sel_inh_n_o (sel_inh_n_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .result_o    (result_o),
    .err_o       (err_o)
);

// File: tb/sim_pot_sar_seq.sv
module sim_pot_sar_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [4:0]  pot_idx_i = '0;
    logic [7:0]  settle_cyc_i = '0;
    logic        cmp_above_i;
    logic [7:0]  dac_data_o;
    logic        dac_lo_stb_o, dac_hi_stb_o;
    logic [2:0]  pot_code_o;
    logic [2:0]  sel_inh_n_o;
    logic        busy_o, done_o, err_o;
    logic [11:0] result_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    // Analog model: DAC register plus a threshold comparator that misreports
    // while the DAC output is still settling.
    int         wiper = 0;
    int         cur_settle = 0;
    logic [7:0] lo_byte = '0;
    logic [11:0] dac_q = '0;
    int         glitch = 0;

    assign cmp_above_i = (glitch != 0) ? 1'b1 : (wiper > int'(dac_q));

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (dac_lo_stb_o) lo_byte <= dac_data_o;
        if (dac_hi_stb_o) begin
            dac_q  <= {dac_data_o[3:0], lo_byte};
            glitch <= cur_settle;
        end else if (glitch > 0) begin
            glitch <= glitch - 1;
        end
    end

    pot_sar_seq u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .pot_idx_i   (pot_idx_i),
        .settle_cyc_i(settle_cyc_i),
        .cmp_above_i (cmp_above_i),
        .dac_data_o  (dac_data_o),
        .dac_lo_stb_o(dac_lo_stb_o),
        .dac_hi_stb_o(dac_hi_stb_o),
        .pot_code_o  (pot_code_o),
        .sel_inh_n_o (sel_inh_n_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .result_o    (result_o),
        .err_o       (err_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sar_expect(input int w);
        if (w <= 0) return 0;
        if (w > 4096) return 4095;
        return w - 1;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic t_reset();
        @(negedge clk);
        chk(busy_o == 0 && done_o == 0 && err_o == 0, "R10 flags", busy_o, 0);
        chk(!dac_lo_stb_o && !dac_hi_stb_o, "R10 strobes", dac_lo_stb_o, 0);
        chk(sel_inh_n_o == 3'b111, "R10 inhibits", sel_inh_n_o, 7);
        chk(result_o == 0, "R10 result", result_o, 0);
        chk(pot_code_o == 0, "R1 code after reset", pot_code_o, 0);
    endtask

    task automatic run_conv(input logic [4:0] idx, input int w, input int s, input bit intrude);
        int n_lo = 0, n_hi = 0, hi_at = -1, exp_res;
        bit prev_lo = 0, bad_order = 0, bad_inh = 0, bad_gap = 0, bad_hi = 0;
        logic [2:0] exp_inh;
        int first_trial = -1;
        exp_inh    = ~(3'b001 << idx[4:3]);
        exp_res    = sar_expect(w);
        wiper      = w;
        cur_settle = s;
        pot_idx_i    = idx;
        settle_cyc_i = 8'(s);
        start_i      = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1, "R3 busy in select", busy_o, 1);
        chk(sel_inh_n_o == 3'b111, "R3 inhibits high in select", sel_inh_n_o, 7);
        chk(pot_code_o == idx[2:0], "R1 code latched", pot_code_o, idx[2:0]);
        for (int k = 0; k < 20000; k++) begin
            @(negedge clk);
            if (dac_lo_stb_o) begin
                n_lo++;
                if (sel_inh_n_o != exp_inh) bad_inh = 1;
                if (hi_at >= 0 && k - hi_at != s + 3) bad_gap = 1;
                if (first_trial < 0) first_trial = dac_data_o;
            end
            if (dac_hi_stb_o) begin
                n_hi++;
                if (!prev_lo) bad_order = 1;
                if (dac_data_o[7:4] != 0) bad_hi = 1;
                if (sel_inh_n_o != exp_inh) bad_inh = 1;
                if (n_hi == 1) first_trial = first_trial | (int'(dac_data_o[3:0]) << 8);
                hi_at = k;
            end
            prev_lo = dac_lo_stb_o;
            if (intrude && k == 40) begin
                pot_idx_i = 5'd0; settle_cyc_i = 8'd0; start_i = 1'b1;
            end
            if (intrude && k == 41) start_i = 1'b0;
            if (done_o) break;
        end
        chk(done_o == 1, "R8 done seen", done_o, 1);
        chk(result_o == 12'(exp_res), intrude ? "R9 result of running conversion" : "R7 result",
            result_o, exp_res);
        chk(first_trial == 12'h800, "R7 first trial", first_trial, 12'h800);
        chk(n_lo == 12 && n_hi == 12, "R5 trial count", n_lo, 12);
        chk(!bad_order && !bad_hi, "R5 byte order and high byte", bad_order, 0);
        chk(!bad_inh, "R4 single inhibit low", bad_inh, 0);
        chk(!bad_gap, "R6 settle spacing", bad_gap, 0);
        chk(pot_code_o == idx[2:0], intrude ? "R9 code kept" : "R1 code held",
            pot_code_o, idx[2:0]);
        @(negedge clk);
        chk(done_o == 0 && busy_o == 0, "R8 done one cycle", done_o, 0);
        chk(sel_inh_n_o == 3'b111, "R3 inhibits high after", sel_inh_n_o, 7);
        chk(result_o == 12'(exp_res), "R8 result held", result_o, exp_res);
        chk(pot_code_o == idx[2:0], "R1 code held after done", pot_code_o, idx[2:0]);
    endtask

    task automatic t_reject(input logic [4:0] idx);
        logic [2:0] code_before;
        code_before = pot_code_o;
        pot_idx_i = idx;
        start_i   = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(err_o == 1, "R2 error pulse", err_o, 1);
        chk(busy_o == 0, "R2 no conversion", busy_o, 0);
        chk(sel_inh_n_o == 3'b111, "R2 inhibits high", sel_inh_n_o, 7);
        chk(pot_code_o == code_before, "R2 code unchanged", pot_code_o, code_before);
        @(negedge clk);
        chk(err_o == 0 && busy_o == 0, "R2 error one cycle", err_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        run_conv(5'd0, 1000, 0, 1'b0);
        run_conv(5'd11, 2048, 3, 1'b0);
        run_conv(5'd23, 4095, 5, 1'b0);
        run_conv(5'd17, 0, 1, 1'b0);
        run_conv(5'd6, 5000, 2, 1'b0);
        run_conv(5'd20, 1, 4, 1'b1);
        t_reject(5'd24);
        t_reject(5'd31);
        run_conv(5'd2, 3000, 0, 1'b0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule